// File: doc/BRIEF.md
# Zero-turnaround synchronous burst SRAM

A single-port static RAM with a shared bidirectional data bus. Every rising clock edge can start an access, and reads and writes may alternate on consecutive edges with no idle cycle in between. An access is started either by a fresh address under chip select, or by continuing the current access with the burst-advance input. A two-bit beat counter then moves the low address bits in either a wrapping linear order or an interleaved (XOR) order. Which order is used depends on a pin that is read asynchronously.

Reads are flow-through. Once the edge that takes the read address has passed, the array word goes straight onto the bus within that same cycle, with no output register. Writes are late: the host drives the write data during the cycle after the write address. The block captures that data at the following edge into a single pending-write slot. The array is updated from that slot only when the next write's data arrives. A read that hits the pending address takes the pending byte lanes from the slot and the rest from the array, so it always sees the newest data.

Data flows over a shared tri-state bus. A valid/ready handshake would break zero turnaround, so there is none. All pins are plain.

Top module: `zbt_sram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with chip select low, the block does not drive `dq`. Reset also clears the pending write.
- R2: For a read taken at an edge, the word at the effective address is on `dq` before the next edge. No further edge is needed.
- R3: Write data is sampled from `dq` at the edge one cycle after its address. It is stored to the effective address of that write with no other input needed.
- R4: `lane_we[0]` enables bits 8:0 and `lane_we[1]` enables bits 17:9. These enables are sampled with the address. A lane whose enable is 0 keeps its old contents.
- R5: Writes and reads may alternate on consecutive edges with no idle cycle. A read of the word written by the immediately preceding access returns the new data.
- R6: While an access is active, `burst_next` high at an edge continues it as a new beat. That beat keeps the access's type and upper address, and ignores `cs`, `we` and `addr`. When no access is active, `burst_next` has no effect and the cycle is decoded from `cs`.
- R7: With `order_linear` = 1, beat n of a burst starting at low bits s uses low bits (s + n) mod 4, and the upper bits stay the same.
- R8: With `order_linear` = 0, beat n uses low bits s XOR n.
- R9: `order_linear` acts without a clock. Changing it during a read beat changes the word on `dq` within that cycle.
- R10: `dq` is driven only during a read cycle with `oe` = 1. `oe` acts asynchronously.
- R11: An edge with `cs` = 0 and `burst_next` = 0 leaves the block idle. `dq` is released in the cycle that follows.
- R12: During the data cycle of a write, the block leaves `dq` undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| cs | input | 1 | Chip select: start a new access at this edge |
| we | input | 1 | 1 = write, 0 = read, for a new access |
| burst_next | input | 1 | Continue the active access with the next beat |
| addr | input | 10 | Word address of a new access |
| lane_we | input | 2 | Per-lane write enables, sampled with the address |
| oe | input | 1 | Asynchronous output enable |
| order_linear | input | 1 | Asynchronous burst order: 1 linear, 0 interleaved |
| dq | inout | 18 | Shared data bus |

## Verification
The assertions assume that `order_linear` does not change between a write beat's address edge and its data edge. They also assume that the host releases `dq` in every cycle where a read is expected, and drives it in every write data cycle. The stimulus keeps the order pin fixed over random blocks and changes it only after two idle cycles. The one exception is a directed probe in the middle of a read beat. The host bus driver is turned on and off just after each edge, based on the predicted state of the access. Because of this, the write data is present across the capturing edge and is never driven during a read.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  // Decoded meaning of one clock edge at the control inputs.
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_NEW  = 2'd1,
    CMD_BEAT = 2'd2
  } cmd_e;

  // Default geometry shared by the modules.
  localparam int unsigned DEF_DEPTH  = 1024;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_LANE_W = 9;
  localparam int unsigned DEF_CNT_W  = 2;

endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LANES = 2,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             we,
  input  logic             burst_next,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_we,
  output logic             act_q,
  output logic             wr_q,
  output logic [AW-1:0]    base_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [LANES-1:0] be_q
);

  cmd_e cmd;

  // A beat continues only a live access; otherwise chip select decides.
  always_comb begin
    if (burst_next && act_q) cmd = CMD_BEAT;
    else if (cs)             cmd = CMD_NEW;
    else                     cmd = CMD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      be_q   <= '0;
    end else begin
      case (cmd)
        CMD_BEAT: begin
          cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
          be_q  <= lane_we;
        end
        CMD_NEW: begin
          act_q  <= 1'b1;
          wr_q   <= we;
          base_q <= addr;
          cnt_q  <= '0;
          be_q   <= lane_we;
        end
        default: begin
          act_q <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] cnt,
  input  logic             order_linear,
  output logic [CNT_W-1:0] lo
);

  logic [CNT_W-1:0] lin_lo;
  logic [CNT_W-1:0] xor_lo;

  assign lin_lo = start + cnt;
  assign xor_lo = start ^ cnt;
  assign lo     = order_linear ? lin_lo : xor_lo;

endmodule

// File: rtl/zbt_late_write.sv
module zbt_late_write #(
  parameter int DEPTH  = 1024,
  parameter int AW     = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [AW-1:0]    cap_addr,
  input  logic [LANES-1:0] cap_be,
  input  logic [LANES*LANE_W-1:0] cap_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic             pend_vld,
  output logic [AW-1:0]    pend_addr
);

  localparam int DW = LANES * LANE_W;

  logic [LANES-1:0] pend_be;
  logic [DW-1:0]    pend_data;
  logic             commit;
  logic             addr_hit;

  // The slot is retired into the array when the next write's data lands.
  assign commit   = cap_en && pend_vld;
  assign addr_hit = pend_vld && (pend_addr == rd_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_be   <= '0;
      pend_data <= '0;
    end else if (cap_en) begin
      pend_vld  <= 1'b1;
      pend_addr <= cap_addr;
      pend_be   <= cap_be;
      pend_data <= cap_data;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (commit && pend_be[l]) mem[pend_addr] <= pend_data[l*LANE_W +: LANE_W];
    end

    assign rd_data[l*LANE_W +: LANE_W] = (addr_hit && pend_be[l])
                                         ? pend_data[l*LANE_W +: LANE_W]
                                         : mem[rd_addr];
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int DEPTH  = DEF_DEPTH,
  parameter int LANES  = DEF_LANES,
  parameter int LANE_W = DEF_LANE_W,
  parameter int CNT_W  = DEF_CNT_W,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             we,
  input  logic             burst_next,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_we,
  input  logic             oe,
  input  logic             order_linear,
  inout  wire  [DW-1:0]    dq
);

  logic             act_q;
  logic             wr_q;
  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LANES-1:0] be_q;
  logic [CNT_W-1:0] beat_lo;
  logic [AW-1:0]    eff_addr;
  logic [DW-1:0]    rd_data;
  logic             pend_vld;
  logic [AW-1:0]    pend_addr;
  logic             bus_en;
  logic             cap_en;

  zbt_ctrl #(.AW(AW), .LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .burst_next(burst_next),
    .addr(addr), .lane_we(lane_we),
    .act_q(act_q), .wr_q(wr_q), .base_q(base_q), .cnt_q(cnt_q), .be_q(be_q)
  );

  zbt_burst_seq #(.CNT_W(CNT_W)) u_seq (
    .start(base_q[CNT_W-1:0]), .cnt(cnt_q), .order_linear(order_linear), .lo(beat_lo)
  );

  assign eff_addr = {base_q[AW-1:CNT_W], beat_lo};
  assign cap_en   = act_q && wr_q;

  zbt_late_write #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_addr(eff_addr), .cap_be(be_q),
    .cap_data(dq), .rd_addr(eff_addr), .rd_data(rd_data),
    .pend_vld(pend_vld), .pend_addr(pend_addr)
  );

  assign bus_en = oe && act_q && !wr_q;
  assign dq     = bus_en ? rd_data : {DW{1'bz}};

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int AW    = 10,
  parameter int CNT_W = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          we,
  input logic          burst_next,
  input logic          order_linear,
  input logic          act_q,
  input logic          wr_q,
  input logic          bus_en,
  input logic          pend_vld,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] eff_addr,
  input logic [AW-1:0] pend_addr
);

  // R11
  deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !burst_next) |=> !bus_en);

  // R12
  write_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && !burst_next) |=> !bus_en);

  // R6
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_next && act_q) |=> (act_q && $stable(base_q) && $stable(wr_q)));

  // R7
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_next && act_q && order_linear) |=>
      (!order_linear || !$stable(order_linear) ||
       eff_addr[CNT_W-1:0] == $past(eff_addr[CNT_W-1:0]) + {{(CNT_W-1){1'b0}}, 1'b1}));

  // R3
  write_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && wr_q) |=> (pend_vld && pend_addr == $past(eff_addr)));

endmodule

bind zbt_sram zbt_sram_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .burst_next(burst_next),
  .order_linear(order_linear), .act_q(act_q), .wr_q(wr_q), .bus_en(bus_en),
  .pend_vld(pend_vld), .base_q(base_q), .eff_addr(eff_addr), .pend_addr(pend_addr)
);

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;

  localparam int DEPTH = 1024;
  localparam int AW    = 10;
  localparam int DW    = 18;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, cs, we, burst_next, oe, order_linear;
  logic [AW-1:0] addr;
  logic [1:0]    lane_we;
  logic [DW-1:0] tb_dq;
  logic          tb_drv;
  wire  [DW-1:0] dq;

  assign dq = tb_drv ? tb_dq : {DW{1'bz}};

  zbt_sram dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .burst_next(burst_next),
    .addr(addr), .lane_we(lane_we), .oe(oe), .order_linear(order_linear), .dq(dq)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] model [DEPTH];

  // Predicted access state, derived from the requirements only.
  logic          p_act = 1'b0;
  logic          p_wr = 1'b0;
  logic [AW-1:0] p_base = '0;
  logic [1:0]    p_cnt = '0;

  function automatic logic [1:0] beat_lo(logic [1:0] s, logic [1:0] n, logic lin);
    return lin ? s + n : s ^ n;
  endfunction

  function automatic logic [AW-1:0] eff();
    return {p_base[AW-1:2], beat_lo(p_base[1:0], p_cnt, order_linear)};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [1:0] be);
    logic [DW-1:0] r;
    r = old;
    if (be[0]) r[8:0]  = nw[8:0];
    if (be[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  function automatic logic [DW-1:0] init_word(int a);
    logic [8:0] av;
    av = 9'(a);
    return {av ^ 9'h1a5, 9'h100 | {1'b0, av[7:0]}};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One access: controls set after a falling edge, bus handled just after
  // the rising edge, result checked at the next falling edge.
  task automatic step(input logic c, input logic w, input logic v, input logic [AW-1:0] a,
                      input logic [1:0] be, input logic [DW-1:0] wd, input string tag);
    cs = c; we = w; burst_next = v; addr = a; lane_we = be;
    if (v && p_act) p_cnt = p_cnt + 2'd1;
    else if (c) begin p_act = 1'b1; p_wr = w; p_base = a; p_cnt = 2'd0; end
    else p_act = 1'b0;
    @(posedge clk);
    #1;
    if (p_act && p_wr) begin
      tb_drv = 1'b1; tb_dq = wd;
      model[eff()] = merge(model[eff()], wd, be);
    end else if (p_act && oe) begin
      tb_drv = 1'b0;
    end else begin
      tb_drv = 1'b1; tb_dq = '0;
    end
    @(negedge clk);
    if (p_act && !p_wr && oe) chk(tag, dq, model[eff()]);
    else if (p_act && p_wr)   chk(tag, dq, wd);
    else                      chk(tag, dq, '0);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, '0, 2'b00, '0, tag);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d [4];
    void'($urandom(32'd1729));
    rst_n = 1'b0; cs = 1'b1; we = 1'b0; burst_next = 1'b0; addr = 10'd5;
    lane_we = 2'b11; oe = 1'b1; order_linear = 1'b1;
    tb_drv = 1'b1; tb_dq = '0;
    repeat (3) @(negedge clk);
    chk("R1 bus idle in reset", dq, '0);
    rst_n = 1'b1;
    idle("R1 idle after reset");

    // Fill the array so every later read has a defined expectation (R3).
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b1, 1'b0, AW'(a), 2'b11, init_word(a), "R3 fill");
    step(1'b1, 1'b0, 1'b0, 10'd0, 2'b00, '0, "R3 read first");
    chk("R3 word 0", dq, init_word(0));
    step(1'b1, 1'b0, 1'b0, 10'd1023, 2'b00, '0, "R2 read last");
    chk("R2 word 1023", dq, init_word(1023));

    // Back-to-back alternation with forwarding.
    step(1'b1, 1'b1, 1'b0, 10'd70, 2'b11, 18'h12345, "R5 wr");
    step(1'b1, 1'b0, 1'b0, 10'd70, 2'b00, '0, "R5 rd");
    chk("R5 read after write", dq, 18'h12345);
    step(1'b1, 1'b1, 1'b0, 10'd71, 2'b11, 18'h0beef, "R5 wr");
    step(1'b1, 1'b0, 1'b0, 10'd70, 2'b00, '0, "R5 rd");
    chk("R5 older word", dq, 18'h12345);
    step(1'b1, 1'b0, 1'b0, 10'd71, 2'b00, '0, "R5 rd");
    chk("R5 newer word", dq, 18'h0beef);

    // Byte lanes.
    step(1'b1, 1'b1, 1'b0, 10'd40, 2'b11, 18'h2aaaa, "R4 full");
    step(1'b1, 1'b1, 1'b0, 10'd40, 2'b01, 18'h3ffff, "R4 low lane");
    step(1'b1, 1'b0, 1'b0, 10'd40, 2'b00, '0, "R4 rd");
    chk("R4 low lane only", dq, 18'h2abff);
    step(1'b1, 1'b1, 1'b0, 10'd40, 2'b10, 18'h00000, "R4 high lane");
    step(1'b1, 1'b0, 1'b0, 10'd40, 2'b00, '0, "R4 rd");
    chk("R4 high lane only", dq, 18'h001ff);
    step(1'b1, 1'b1, 1'b0, 10'd40, 2'b00, 18'h3ffff, "R4 no lane");
    step(1'b1, 1'b0, 1'b0, 10'd40, 2'b00, '0, "R4 rd");
    chk("R4 masked write keeps word", dq, 18'h001ff);

    // Write data cycle: block must not drive (bench drives zero).
    step(1'b1, 1'b1, 1'b0, 10'd60, 2'b11, 18'h00000, "R12 write cycle bus");

    // Linear burst from 9: 9,10,11,8, wrap to 9; junk on ignored inputs.
    idle("R11"); idle("R11");
    step(1'b1, 1'b0, 1'b0, 10'd9, 2'b00, '0, "R7 start");
    step(1'b1, 1'b1, 1'b1, 10'd300, 2'b11, 18'h3ffff, "R6 beat ignores cs/we/addr");
    chk("R7 beat1", dq, model[10]);
    step(1'b0, 1'b1, 1'b1, 10'd500, 2'b00, '0, "R7 beat2");
    chk("R7 beat2", dq, model[11]);
    step(1'b0, 1'b0, 1'b1, 10'd0, 2'b00, '0, "R7 beat3");
    chk("R7 beat3 wraps", dq, model[8]);
    step(1'b0, 1'b0, 1'b1, 10'd0, 2'b00, '0, "R7 beat4");
    chk("R7 counter wraps", dq, model[9]);

    // Interleaved burst from 9: 9,8,11,10.
    idle("R11");
    order_linear = 1'b0;
    idle("R11");
    step(1'b1, 1'b0, 1'b0, 10'd9, 2'b00, '0, "R8 start");
    step(1'b0, 1'b0, 1'b1, 10'd0, 2'b00, '0, "R8 beat1");
    chk("R8 beat1", dq, model[8]);
    step(1'b0, 1'b0, 1'b1, 10'd0, 2'b00, '0, "R8 beat2");
    chk("R8 beat2", dq, model[11]);
    step(1'b0, 1'b0, 1'b1, 10'd0, 2'b00, '0, "R8 beat3");
    chk("R8 beat3", dq, model[10]);

    // Interleaved write burst from 13: 13,12,15,14.
    for (int i = 0; i < 4; i++) d[i] = 18'h10000 | DW'(i * 18'h111 + 18'h0a5);
    idle("R11");
    step(1'b1, 1'b1, 1'b0, 10'd13, 2'b11, d[0], "R8 wr");
    for (int i = 1; i < 4; i++) step(1'b0, 1'b0, 1'b1, 10'd0, 2'b11, d[i], "R6 write beat keeps type");
    idle("R11");
    order_linear = 1'b1;
    idle("R11");
    step(1'b1, 1'b0, 1'b0, 10'd12, 2'b00, '0, "R8 rd");
    chk("R8 wr order 12", dq, d[1]);
    step(1'b1, 1'b0, 1'b0, 10'd15, 2'b00, '0, "R8 rd");
    chk("R8 wr order 15", dq, d[2]);
    step(1'b1, 1'b0, 1'b0, 10'd14, 2'b00, '0, "R8 rd");
    chk("R8 wr order 14", dq, d[3]);
    step(1'b1, 1'b0, 1'b0, 10'd13, 2'b00, '0, "R8 rd");
    chk("R8 wr order 13", dq, d[0]);

    // Asynchronous order pin on a read beat: beat1 from 9 is 10 or 8.
    idle("R11");
    step(1'b1, 1'b0, 1'b0, 10'd9, 2'b00, '0, "R9 start");
    step(1'b0, 1'b0, 1'b1, 10'd0, 2'b00, '0, "R9 beat");
    order_linear = 1'b0;
    #1 chk("R9 interleaved without edge", dq, model[8]);
    order_linear = 1'b1;
    #1 chk("R9 linear again", dq, model[10]);
    idle("R11");

    // Output enable.
    oe = 1'b0;
    step(1'b1, 1'b0, 1'b0, 10'd20, 2'b00, '0, "R10 oe low released");
    tb_drv = 1'b0;
    oe = 1'b1;
    #1 chk("R10 oe async", dq, model[20]);

    // Deselect and advance without an access.
    step(1'b1, 1'b0, 1'b0, 10'd21, 2'b00, '0, "R2 rd");
    idle("R11 deselect releases bus");
    step(1'b0, 1'b0, 1'b1, 10'd22, 2'b00, '0, "R6 advance while idle");
    step(1'b1, 1'b0, 1'b1, 10'd22, 2'b00, '0, "R6 advance while idle takes cs");
    chk("R6 new read 22", dq, model[22]);

    // Constrained random blocks.
    for (int blk = 0; blk < 120; blk++) begin
      oe = 1'b1;
      idle("R11");
      order_linear = 1'($urandom % 2);
      idle("R11");
      for (int k = 0; k < 24; k++) begin
        int op;
        logic [AW-1:0] ra;
        op = int'($urandom % 20);
        ra = AW'(64 + ($urandom % 16));
        oe = (($urandom % 10) != 0);
        if (op < 8)       step(1'b1, 1'b0, 1'b0, ra, 2'($urandom), DW'($urandom), "R5 random read");
        else if (op < 15) step(1'b1, 1'b1, 1'b0, ra, 2'($urandom), DW'($urandom), "R4 random write");
        else if (op < 18) step(1'($urandom), 1'($urandom), 1'b1, ra, 2'($urandom), DW'($urandom), "R6 random beat");
        else              step(1'b0, 1'($urandom), 1'b0, ra, 2'($urandom), DW'($urandom), "R11 random idle");
      end
    end
    oe = 1'b1;
    idle("R11");

    summary();
    $finish;
  end

endmodule